// File: doc/BRIEF.md
# Strobe-Clocked Serial Readout of a Tone-Pair Digit

This block sits behind a tone-pair decoder and hands the decoded 4-bit digit to a controller over one output pin. The controller sees the validated steering signal go high and then applies pulses on a strobe input. The first strobe rising edge captures the digit code and puts its least significant bit on the pin. The next three rising edges move the higher bits out in order.

The same pin is shared with an energy-detect flag from a call-progress detector. The pin carries that flag whenever no readout is in progress. Both the strobe and the steering input come from outside the clock domain. They are synchronised and edge-detected, so each high and each low phase of a strobe pulse must last several system clocks. A powerdown input aborts a readout and leaves the block ready to capture again.

Top module: `dtmf_serial_readout`

## Requirements
- R1: A full readout takes exactly four strobe pulses. After pulse n (n = 1..4) rises, `sd_out` shows bit n-1 of the captured code, so bits leave least significant first.
- R2: The first strobe rising edge of a readout captures `digit_in`. A later change of `digit_in` during that readout does not change the bits still to be shown.
- R3: Each of the second, third and fourth strobe rising edges moves the next more significant captured bit onto `sd_out`. The pin holds that bit through the following low phase, until the next rising edge.
- R4: While a readout is partly done (one to three rising edges seen, or four rising edges with the last falling edge still pending), a steering rising edge does not arm a new capture. The remaining pulses finish the old code, and a strobe pulse after that is ignored.
- R5: After the fourth falling edge, further strobe pulses are ignored and `sd_out` keeps following `energy_in`. This lasts until the next rising edge of `steer_in`, which arms the next capture.
- R6: `sd_out` equals `energy_in` at all times, except from the first strobe rising edge to the fourth strobe falling edge of a readout. Inside that window it shows the captured bit even when the energy flag differs.
- R7: After reset, `sd_out` follows `energy_in`, no bit has been read out, and capture is armed. The first strobe pulse after reset therefore captures a digit without a steering edge.
- R8: Powerdown (`pwrdn` high) abandons any readout in progress, returns `sd_out` to `energy_in` and re-arms capture. After it is released, one strobe pulse captures the current `digit_in`.
- R9: The block sends the code bits unchanged. The code convention is: keys 1 to 9 are their own binary values (7 = 0111, 9 = 1001), 0 = 1010, * = 1011, # = 1100, A = 1101, B = 1110, C = 1111, and D = 0000.
- R10: With `SYNC_STAGES` = 2, the pin changes on the third rising clock edge after the strobe input changes, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwrdn | input | 1 | Powerdown, active high; aborts a readout and re-arms capture |
| steer_in | input | 1 | Validated steering signal from the decoder; asynchronous |
| digit_in | input | DIGIT_W | Decoded digit code |
| ack_in | input | 1 | Readout strobe from the controller; idles low; asynchronous |
| energy_in | input | 1 | Energy-detect flag from the call-progress detector |
| sd_out | output | 1 | Serial data, or the energy flag outside a readout |

## Verification
The embedded assertions check, on every cycle, the properties that involve a single step:
- the bit counter stays in range;
- capture is never armed during a readout;
- a first strobe edge latches bit 0;
- each later edge advances the count by one;
- the last falling edge closes the window and disarms capture;
- an unarmed idle block ignores strobe edges.

Other behaviours only the bench's scenarios can show:
- whole readouts of every key code, with the bit order checked at the pin;
- a digit change after capture;
- a steering edge in the middle of a readout;
- pulses beyond the fourth;
- a powerdown in the middle of a readout;
- the exact synchroniser latency.

// File: rtl/dtmf_serial_readout.sv
module dtmf_serial_readout #(
  parameter int DIGIT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwrdn,
  input  logic               steer_in,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               ack_in,
  input  logic               energy_in,
  output logic               sd_out
);
  localparam int CNT_W = $clog2(DIGIT_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGIT_W);

  logic [SYNC_STAGES-1:0] ack_sync, steer_sync;
  logic ack_prev, steer_prev;
  logic [DIGIT_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_sync   <= '0;
      steer_sync <= '0;
      ack_prev   <= 1'b0;
      steer_prev <= 1'b0;
    end else begin
      ack_sync   <= {ack_sync[SYNC_STAGES-2:0], ack_in};
      steer_sync <= {steer_sync[SYNC_STAGES-2:0], steer_in};
      ack_prev   <= ack_sync[SYNC_STAGES-1];
      steer_prev <= steer_sync[SYNC_STAGES-1];
    end

  wire ack_rise   = ack_sync[SYNC_STAGES-1] & ~ack_prev;
  wire ack_fall   = ~ack_sync[SYNC_STAGES-1] & ack_prev;
  wire steer_rise = steer_sync[SYNC_STAGES-1] & ~steer_prev;
  wire window     = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      armed <= 1'b1;
    end else if (pwrdn) begin
      shreg <= '0;
      cnt   <= '0;
      armed <= 1'b1;
    end else if (!window) begin
      if (ack_rise && armed) begin
        shreg <= digit_in;
        cnt   <= CNT_W'(1);
        armed <= 1'b0;
      end else if (steer_rise) begin
        armed <= 1'b1;
      end
    end else begin
      if (ack_rise && cnt != LAST) begin
        shreg <= shreg >> 1;
        cnt   <= cnt + CNT_W'(1);
      end else if (ack_fall && cnt == LAST) begin
        cnt <= '0;
      end
    end

  assign sd_out = window ? shreg[0] : energy_in;

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_first_latch_r2: assert property (@(posedge clk) disable iff (!rst_n || pwrdn)
    (!window && armed && ack_rise) |=> (cnt == CNT_W'(1) && sd_out == $past(digit_in[0])));

  p_shift_step_r3: assert property (@(posedge clk) disable iff (!rst_n || pwrdn)
    (window && cnt != LAST && ack_rise) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_no_arm_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    window |-> !armed);

  p_ignore_extra_r5: assert property (@(posedge clk) disable iff (!rst_n || pwrdn)
    (!window && !armed && !steer_rise) |=> (!window && !armed));

  p_close_window_r6: assert property (@(posedge clk) disable iff (!rst_n || pwrdn)
    (cnt == LAST && ack_fall) |=> (!window && !armed));

  p_pwrdn_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> (!window && armed));
endmodule

// File: tb/dtmf_serial_readout_test.sv
module dtmf_serial_readout_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn = 1'b0;
  logic steer_in = 1'b0;
  logic [3:0] digit_in = 4'd0;
  logic ack_in = 1'b0;
  logic energy_in = 1'b0;
  logic sd_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dtmf_serial_readout uut (
    .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .steer_in(steer_in),
    .digit_in(digit_in), .ack_in(ack_in), .energy_in(energy_in), .sd_out(sd_out)
  );

  function automatic logic [3:0] key_code(input int k);
    if (k == 0) return 4'b1010;
    if (k <= 9) return 4'(k);
    if (k == 15) return 4'b0000;
    return 4'(k + 1);
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: sd_out=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_hi;
    ack_in = 1'b1; wait_n(6);
  endtask

  task automatic ack_lo;
    ack_in = 1'b0; wait_n(6);
  endtask

  task automatic present(input logic [3:0] code);
    digit_in = code;
    steer_in = 1'b0; wait_n(6);
    steer_in = 1'b1; wait_n(6);
  endtask

  task automatic read_all(input logic [3:0] code, input string req);
    for (int b = 0; b < 4; b++) begin
      energy_in = ~code[b];
      ack_hi;
      check(sd_out, code[b], req);
      energy_in = $urandom_range(0, 1);
      ack_lo;
      if (b < 3) check(sd_out, code[b], {req, " R3 low phase"});
      else check(sd_out, energy_in, {req, " R6 after last fall"});
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary;
  end

  initial begin
    void'($urandom(32'd4242));
    wait_n(3);
    energy_in = 1'b1; #1 check(sd_out, 1'b1, "R7 reset follows energy");
    energy_in = 1'b0; #1 check(sd_out, 1'b0, "R7 reset follows energy");
    rst_n = 1'b1;
    wait_n(2);

    // R7: capture armed by reset, no steering edge needed
    digit_in = key_code(7);
    read_all(key_code(7), "R7 first readout after reset");

    // R10: latency of three clock edges
    present(4'b0001);
    energy_in = 1'b0;
    ack_in = 1'b1;
    wait_n(2); check(sd_out, 1'b0, "R10 no change before third edge");
    wait_n(1); check(sd_out, 1'b1, "R10 change on third edge");
    wait_n(3);
    ack_lo;
    for (int b = 1; b < 4; b++) begin ack_hi; check(sd_out, 1'b0, "R10 rest bits"); ack_lo; end

    // R2: digit change after capture does not disturb readout
    present(key_code(9));
    energy_in = 1'b0;
    ack_hi; check(sd_out, 1'b1, "R2 bit0 of 9");
    digit_in = 4'b0110;
    ack_lo;
    ack_hi; check(sd_out, 1'b0, "R2 bit1 of 9");
    ack_lo;
    ack_hi; check(sd_out, 1'b0, "R2 bit2 of 9");
    ack_lo;
    energy_in = 1'b0;
    ack_hi; check(sd_out, 1'b1, "R2 bit3 of 9 R6 high during fourth pulse");
    ack_lo; check(sd_out, 1'b0, "R6 energy after fourth fall");

    // R5: extra pulses ignored
    for (int i = 0; i < 3; i++) begin
      digit_in = 4'b1111;
      energy_in = i[0];
      ack_hi; check(sd_out, energy_in, "R5 extra pulse ignored");
      ack_lo; check(sd_out, energy_in, "R5 extra pulse ignored");
    end

    // R4: steering edge mid-readout blocked
    present(key_code(5));
    energy_in = 1'b0;
    ack_hi; ack_lo; ack_hi; ack_lo;
    digit_in = key_code(9);
    steer_in = 1'b0; wait_n(6); steer_in = 1'b1; wait_n(6);
    energy_in = 1'b0;
    ack_hi; check(sd_out, 1'b1, "R4 bit2 of old code 5");
    ack_lo;
    energy_in = 1'b1;
    ack_hi; check(sd_out, 1'b0, "R4 bit3 of old code 5");
    ack_lo;
    energy_in = 1'b0;
    ack_hi; check(sd_out, 1'b0, "R4 pulse after finish ignored");
    ack_lo;
    present(key_code(9));
    read_all(key_code(9), "R4 next capture after steering edge");

    // R8: powerdown mid-readout
    present(key_code(12));
    energy_in = 1'b0;
    ack_hi; ack_lo; ack_hi;
    pwrdn = 1'b1; wait_n(3);
    energy_in = 1'b1; #1 check(sd_out, 1'b1, "R8 powerdown selects energy");
    ack_in = 1'b0; wait_n(6);
    pwrdn = 1'b0; wait_n(2);
    digit_in = key_code(3);
    read_all(key_code(3), "R8 re-armed after powerdown");

    // R1/R9: random keys
    for (int it = 0; it < 40; it++) begin
      int k;
      k = $urandom_range(0, 15);
      present(key_code(k));
      read_all(key_code(k), $sformatf("R1 R9 key %0d", k));
    end

    // R9: directed code values
    present(key_code(0));  read_all(4'b1010, "R9 key 0");
    present(key_code(15)); read_all(4'b0000, "R9 key D");
    present(key_code(11)); read_all(4'b1100, "R9 key #");

    summary;
  end
endmodule